// File: doc/BRIEF.md
# Two-Bank Static RAM with Run-Time x16/x8 Organisation

This block is a clocked, synthesizable model of a static RAM made from two equal storage banks. The most significant address bit picks the bank and the remaining bits pick a 16-bit word inside it. The usual static-RAM control set is sampled on each rising clock edge: a low-true and a high-true chip select, a low-true enable for each byte lane, a low-true write strobe, a low-true output enable, and a low-true byte-mode select. The bidirectional data bus is split into separate input, output and per-bit drive-enable vectors, so a pad ring or a bench can rebuild the tri-state bus.

In x16 organisation the two byte lanes are reached independently. In x8 organisation only the low data byte carries data, and the top data input bit becomes the least significant address bit. It picks the low or high byte of the addressed word. Two flags report misuse: one for an x8 cycle with only one lane enabled, and one for an address that moves while the write strobe stays low.

Top module: `twin_bank_sram`

## Requirements
- R1: While reset is asserted, and until the first sampled access after it is released, `dq_oe`, `mode_err` and `hold_err` are all zero.
- R2: The device is deselected when `cs_n` is 1, when `cs` is 0, or when both `lo_en_n` and `hi_en_n` are 1. A deselected cycle drives no data bit and changes no stored bit.
- R3: A write stores data when `we_n` is 0, `cs_n` is 0, `cs` is 1 and at least one byte enable is 0. The value of `oe_n` has no effect on a write.
- R4: In x16 organisation (`byte_n` = 1), `lo_en_n` gates data bits 7:0 and `hi_en_n` gates data bits 15:8, for both reads and writes. A lane whose enable is 1 keeps its stored value and is not driven.
- R5: A read (`we_n` = 1, `oe_n` = 0, device selected) presents the stored data on `dq_out` with the matching `dq_oe` bits set, one clock after the edge that samples the request.
- R6: Address bit `addr[ADDR_W]` selects bank 0 (value 0) or bank 1 (value 1). The two banks hold independent contents at equal word indices.
- R7: A selected cycle with `we_n` = 1 and `oe_n` = 1 drives no data bit and writes nothing.
- R8: In x8 organisation (`byte_n` = 0, both enables 0), `dq_in[15]` is the byte address. A value of 0 selects bits 7:0 of the word and 1 selects bits 15:8. Writes take `dq_in[7:0]`. Reads return the chosen byte on `dq_out[7:0]` with `dq_oe` = 16'h00FF. Bits 15:8 are never driven in x8 organisation.
- R9: An otherwise selected x8 cycle with exactly one byte enable at 0 is treated as deselected: no write and no drive. `mode_err` is 1 for the following clock.
- R10: When `we_n` is 0 on two consecutive sampling edges and `addr` differs between them, `hold_err` is 1 for the following clock. The write on the second edge still takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous low-true reset, released synchronously inside |
| cs_n | input | 1 | Low-true chip select |
| cs | input | 1 | High-true chip select |
| lo_en_n | input | 1 | Low-true enable, byte lane 7:0 |
| hi_en_n | input | 1 | Low-true enable, byte lane 15:8 |
| we_n | input | 1 | Low-true write strobe |
| oe_n | input | 1 | Low-true output enable |
| byte_n | input | 1 | Low selects x8 organisation |
| addr | input | ADDR_W+1 | Word address; top bit is the bank |
| dq_in | input | 16 | Data bus as seen entering the device; bit 15 is the byte address in x8 |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-bit drive enable for `dq_out` |
| mode_err | output | 1 | Pulse: x8 cycle with a single lane enabled |
| hold_err | output | 1 | Pulse: address moved during a held write strobe |

## Verification
The bench builds the block with `ADDR_W` = 3, so each bank holds eight words. The whole address space can then be written and read back in a few dozen cycles. Every location, both banks and both byte addresses in x8 organisation are therefore reached deterministically before a long random phase. In that random phase, x8 and x16 cycles, single-lane reads and writes, and address changes under a held strobe hit stored contents that the reference model already knows in full.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int unsigned LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] wr_lane;
    logic [LANES-1:0] rd_lane;
    logic             x8;
    logic             split;
  } tbs_op_t;
endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
(
  input  logic    cs_n,
  input  logic    cs,
  input  logic    lo_en_n,
  input  logic    hi_en_n,
  input  logic    we_n,
  input  logic    oe_n,
  input  logic    byte_n,
  input  logic    byte_addr,
  output tbs_op_t op
);
  logic             chosen;
  logic             x8;
  logic             split;
  logic             live;
  logic [LANES-1:0] lanes;

  always_comb begin
    chosen = ~cs_n & cs & ~(lo_en_n & hi_en_n);
    x8     = ~byte_n;
    split  = chosen & x8 & (lo_en_n ^ hi_en_n);
    live   = chosen & ~split;
    if (x8) lanes = byte_addr ? 2'b10 : 2'b01;
    else    lanes = {~hi_en_n, ~lo_en_n};
    op.wr_lane = (live & ~we_n)        ? lanes : '0;
    op.rd_lane = (live & we_n & ~oe_n) ? lanes : '0;
    op.x8      = x8;
    op.split   = split;
  end
endmodule

// File: rtl/tbs_bank.sv
module tbs_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          wr_lane,
  input  logic [ADDR_W-1:0]         idx,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) cells[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[idx];
  end
endmodule

// File: rtl/tbs_hold_mon.sv
module tbs_hold_mon #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          hold_err
);
  logic          strobe_q;
  logic [AW-1:0] addr_q;
  logic          err_d;

  always_comb begin
    err_d = strobe_q & ~we_n & (addr != addr_q);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
      hold_err <= 1'b0;
    end else begin
      strobe_q <= ~we_n;
      if (!we_n) addr_q <= addr;
      hold_err <= err_d;
    end
  end

  // R10: a flag can only follow an edge that saw the strobe low
  p_hold_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_q)
    hold_err |-> $past(!we_n));
endmodule

// File: rtl/twin_bank_sram.sv
module twin_bank_sram
  import tbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  cs,
  input  logic                  lo_en_n,
  input  logic                  hi_en_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic                  byte_n,
  input  logic [ADDR_W:0]       addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [2*LANE_W-1:0]   dq_oe,
  output logic                  mode_err,
  output logic                  hold_err
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned NBANK  = 2;

  logic              rst_meta, rst_q;
  tbs_op_t           op;
  logic              bank_sel;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] bank_rd [NBANK];
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] out_d, oe_d;
  logic              out_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  tbs_ctrl u_ctrl (
    .cs_n      (cs_n),
    .cs        (cs),
    .lo_en_n   (lo_en_n),
    .hi_en_n   (hi_en_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .byte_n    (byte_n),
    .byte_addr (dq_in[DATA_W-1]),
    .op        (op)
  );

  assign bank_sel = addr[ADDR_W];
  assign wdata    = op.x8 ? {LANES{dq_in[LANE_W-1:0]}} : dq_in;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LANES-1:0] wr_here;
    assign wr_here = (bank_sel == b[0]) ? op.wr_lane : '0;

    tbs_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
      .clk     (clk),
      .wr_lane (wr_here),
      .idx     (addr[ADDR_W-1:0]),
      .wdata   (wdata),
      .rdata   (bank_rd[b])
    );
  end

  assign rd_word = bank_rd[bank_sel];

  always_comb begin
    oe_d = '0;
    out_d = '0;
    if (op.x8) begin
      if (|op.rd_lane) begin
        oe_d[LANE_W-1:0]  = '1;
        out_d[LANE_W-1:0] = op.rd_lane[1] ? rd_word[DATA_W-1:LANE_W]
                                          : rd_word[LANE_W-1:0];
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (op.rd_lane[l]) begin
          oe_d[l*LANE_W +: LANE_W]  = '1;
          out_d[l*LANE_W +: LANE_W] = rd_word[l*LANE_W +: LANE_W];
        end
      end
    end
    out_ld = (|op.rd_lane) | (|dq_oe);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      dq_oe    <= '0;
      dq_out   <= '0;
      mode_err <= 1'b0;
    end else begin
      dq_oe    <= oe_d;
      if (out_ld) dq_out <= out_d;
      mode_err <= op.split;
    end
  end

  tbs_hold_mon #(.AW(ADDR_W + 1)) u_hold (
    .clk      (clk),
    .rst_q    (rst_q),
    .we_n     (we_n),
    .addr     (addr),
    .hold_err (hold_err)
  );

  // R2: a deselected edge leaves the bus undriven
  p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (cs_n || !cs || (lo_en_n && hi_en_n)) |=> (dq_oe == '0));

  // R7: strobe and output enable both high gives no drive
  p_idle_hiz_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (we_n && oe_n) |=> (dq_oe == '0));

  // R8: the upper lane is never driven in x8 organisation
  p_x8_upper_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (!byte_n) |=> (dq_oe[DATA_W-1:LANE_W] == '0));

  // R9: a single-lane x8 cycle raises the flag and drives nothing
  p_split_err_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (!cs_n && cs && !byte_n && (lo_en_n != hi_en_n)) |=> (mode_err && dq_oe == '0));
endmodule

// File: tb/sim_twin_bank_sram.sv
`timescale 1ns/1ps
module sim_twin_bank_sram;
  localparam int AW    = 3;
  localparam int NWORD = 2 << AW;
  localparam real CLK_NS = 4.0;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, cs, lo_en_n, hi_en_n, we_n, oe_n, byte_n;
  logic [AW:0]  addr;
  logic [15:0]  dq_in;
  logic [15:0]  dq_out, dq_oe;
  logic         mode_err, hold_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mdl [NWORD];
  logic [15:0] e_out, e_oe;
  logic        e_merr, e_herr;
  logic        prv_we;
  logic [AW:0] prv_addr;

  always #(CLK_NS/2) clk = ~clk;

  twin_bank_sram #(.ADDR_W(AW), .LANE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .lo_en_n(lo_en_n),
    .hi_en_n(hi_en_n), .we_n(we_n), .oe_n(oe_n), .byte_n(byte_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .mode_err(mode_err), .hold_err(hold_err)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drv(input logic c_n, input logic c, input logic l_n, input logic h_n,
                     input logic w_n, input logic o_n, input logic b_n,
                     input logic [AW:0] a, input logic [15:0] d);
    cs_n = c_n; cs = c; lo_en_n = l_n; hi_en_n = h_n;
    we_n = w_n; oe_n = o_n; byte_n = b_n; addr = a; dq_in = d;
  endtask

  // behavioural reference for one sampling edge
  task automatic model();
    logic sel, x8, bad, act, hi;
    sel = !cs_n && cs && !(lo_en_n && hi_en_n);
    x8  = !byte_n;
    bad = sel && x8 && (lo_en_n != hi_en_n);
    act = sel && !bad;
    hi  = dq_in[15];
    e_oe = 16'h0; e_out = 16'h0; e_merr = bad;
    e_herr = prv_we && !we_n && (addr != prv_addr);
    prv_we = !we_n; prv_addr = addr;
    if (act && !we_n) begin
      if (x8) begin
        if (hi) mdl[addr][15:8] = dq_in[7:0];
        else    mdl[addr][7:0]  = dq_in[7:0];
      end else begin
        if (!lo_en_n) mdl[addr][7:0]  = dq_in[7:0];
        if (!hi_en_n) mdl[addr][15:8] = dq_in[15:8];
      end
    end else if (act && !oe_n) begin
      if (x8) begin
        e_oe  = 16'h00FF;
        e_out = {8'h00, hi ? mdl[addr][15:8] : mdl[addr][7:0]};
      end else begin
        if (!lo_en_n) e_oe[7:0]  = 8'hFF;
        if (!hi_en_n) e_oe[15:8] = 8'hFF;
        e_out = mdl[addr] & e_oe;
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, "dq_oe", dq_oe, e_oe);
    chk(tag, "dq_out", dq_out & dq_oe, e_out & e_oe);
    chk(tag, "mode_err", {15'h0, mode_err}, {15'h0, e_merr});
    chk(tag, "hold_err", {15'h0, hold_err}, {15'h0, e_herr});
  endtask

  task automatic idle(input string tag);
    drv(1, 0, 1, 1, 1, 1, 1, '0, 16'h0);
    step(tag);
  endtask

  task automatic wr16(input string tag, input logic [AW:0] a, input logic [15:0] d,
                      input logic l_n, input logic h_n, input logic o_n);
    drv(0, 1, l_n, h_n, 0, o_n, 1, a, d);
    step(tag);
    idle(tag);
  endtask

  task automatic rd16(input string tag, input logic [AW:0] a, input logic l_n, input logic h_n);
    drv(0, 1, l_n, h_n, 1, 0, 1, a, 16'h0);
    step(tag);
  endtask

  task automatic wr8(input string tag, input logic [AW:0] a, input logic hi, input logic [7:0] d);
    drv(0, 1, 0, 0, 0, 1, 0, a, {hi, 7'h55, d});
    step(tag);
    idle(tag);
  endtask

  task automatic rd8(input string tag, input logic [AW:0] a, input logic hi);
    drv(0, 1, 0, 0, 1, 0, 0, a, {hi, 15'h2AAA});
    step(tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    prv_we = 1'b0; prv_addr = '0;
    rst_n = 1'b0;
    drv(1, 0, 1, 1, 1, 1, 1, '0, 16'h0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "dq_oe", dq_oe, 16'h0);
    chk("R1", "mode_err", {15'h0, mode_err}, 16'h0);
    chk("R1", "hold_err", {15'h0, hold_err}, 16'h0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R3 / R6: fill both banks, odd words with oe_n low
    for (int a = 0; a < NWORD; a++)
      wr16("R3", a[AW:0], 16'hA50F ^ (a[15:0] * 16'h1111), 1'b0, 1'b0, a[0] ? 1'b0 : 1'b1);
    // R5 / R6: read everything back, one cycle after the sampling edge
    for (int a = 0; a < NWORD; a++) rd16("R6", a[AW:0], 1'b0, 1'b0);
    idle("R5");

    // R4: independent lanes
    wr16("R4", 4'd5, 16'h1234, 1'b0, 1'b1, 1'b1);
    wr16("R4", 4'd5, 16'hABCD, 1'b1, 1'b0, 1'b1);
    rd16("R4", 4'd5, 1'b0, 1'b1);
    rd16("R4", 4'd5, 1'b1, 1'b0);
    rd16("R4", 4'd5, 1'b0, 1'b0);

    // R2: three deselect forms with a write attempt, then read back
    drv(1, 1, 0, 0, 0, 0, 1, 4'd3, 16'hFFFF); step("R2"); idle("R2");
    drv(0, 0, 0, 0, 0, 0, 1, 4'd3, 16'hFFFF); step("R2"); idle("R2");
    drv(0, 1, 1, 1, 0, 0, 1, 4'd3, 16'hFFFF); step("R2"); idle("R2");
    rd16("R2", 4'd3, 1'b0, 1'b0);

    // R7: selected but neither strobe nor output enable
    drv(0, 1, 0, 0, 1, 1, 1, 4'd3, 16'h0000); step("R7");
    rd16("R7", 4'd3, 1'b0, 1'b0);

    // R8: x8 organisation in both banks and both byte addresses
    wr8("R8", 4'd6, 1'b0, 8'h5A);
    wr8("R8", 4'd6, 1'b1, 8'hC3);
    wr8("R8", 4'd14, 1'b1, 8'h7E);
    rd8("R8", 4'd6, 1'b0);
    rd8("R8", 4'd6, 1'b1);
    rd8("R8", 4'd14, 1'b1);
    rd8("R8", 4'd14, 1'b0);
    rd16("R8", 4'd6, 1'b0, 1'b0);
    rd16("R8", 4'd14, 1'b0, 1'b0);

    // R9: x8 with one lane enabled, write and read attempts
    drv(0, 1, 0, 1, 0, 1, 0, 4'd6, 16'h0011); step("R9"); idle("R9");
    drv(0, 1, 1, 0, 1, 0, 0, 4'd6, 16'h8000); step("R9");
    rd16("R9", 4'd6, 1'b0, 1'b0);

    // R10: address moves under a held strobe, then a held strobe at one address
    drv(0, 1, 0, 0, 0, 1, 1, 4'd2, 16'h2222); step("R10");
    drv(0, 1, 0, 0, 0, 1, 1, 4'd4, 16'h4444); step("R10");
    idle("R10");
    drv(0, 1, 0, 0, 0, 1, 1, 4'd9, 16'h9999); step("R10");
    drv(0, 1, 0, 0, 0, 1, 1, 4'd9, 16'h9A9A); step("R10");
    idle("R10");
    rd16("R10", 4'd2, 1'b0, 1'b0);
    rd16("R10", 4'd4, 1'b0, 1'b0);
    rd16("R10", 4'd9, 1'b0, 1'b0);

    // mixed traffic, every cycle against the reference (R5 timing throughout)
    for (int i = 0; i < 600; i++) begin
      drv(($urandom % 5) == 0, ($urandom % 6) != 0, $urandom % 2, $urandom % 2,
          $urandom % 2, $urandom % 2, ($urandom % 3) != 0,
          $urandom % NWORD, $urandom);
      step("R5");
    end
    idle("R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule